// File: doc/BRIEF.md
# Card Command-Line Timing Sequencer

This block is the host side of a flash card's single-wire command line. It accepts one request at a time (a 6-bit command index, a 32-bit argument and the kind of reply expected), turns it into a 48-bit frame and shifts that frame out one bit per clock. The frame carries a CRC7 that the block computes itself. It then listens on the same wire for the card's reply, checks the reply and hands it back with status flags. Finally it holds the line idle for the minimum gap before the next command may begin.

The length of the gap depends on how the last exchange ended. When a reply was received, the gap is counted from its last bit. When a command expects no reply, or the expected reply never comes, the gap is counted from the end of the command or the timeout. A long-reply (identification) command that nobody answers adds the length of a long reply to the gap. The wire is driven only while the host's own frame is on it, and it floats at every other time.

The sequencer has five states. IDLE accepts a request (transition *accept* to SEND). SEND serialises 48 bits (*cmd_done* to GAP when no reply is expected, otherwise to WAIT). WAIT watches for a start bit (*start_seen* to RECV, *no_answer* to GAP). RECV collects the reply (*rsp_done* to GAP). GAP counts the idle gap (*gap_done* to IDLE).

Top module: `cmdline_seq`

## Requirements
- R1: When a request is accepted in IDLE, the 48 command bits appear on `cmd_out` in the 48 cycles that follow, most significant bit first. The frame is a start bit 0, a direction bit 1, the 6-bit index, the 32-bit argument, 7 CRC bits and an end bit 1.
- R2: The 7 CRC bits are the CRC7 of the first 40 frame bits, with generator x^7 + x^3 + 1, a zero initial value and the most significant bit first.
- R3: `cmd_oe` is high in exactly the 48 cycles of the host frame and low from the cycle after the end bit. `req_ready` is never high while `cmd_oe` is high.
- R4: After the last bit of a reply is sampled, `req_ready` stays low for NRC cycles and rises in the cycle after them.
- R5: After a command of kind none (`req_rtype` = 0), `req_ready` stays low for NCC cycles after the end bit and rises in the cycle after them.
- R6: The first 0 seen on `cmd_in` within NCR_MAX cycles after the command's end bit starts a reply. The reply is 48 bits for kinds 1 and 2 and 136 bits for kind 3. One cycle after its last bit, `rsp_valid` pulses for one cycle and `rsp_frame` holds the reply with its last bit at position 0 and zeros above it.
- R7: If a reply of kind 1 or 2 has not started within NCR_MAX cycles, `rsp_valid` pulses with `rsp_timeout` = 1, and `req_ready` rises after a further NCC cycles.
- R8: If a reply of kind 3 has not started within NCR_MAX cycles, `rsp_valid` pulses with `rsp_timeout` = 1, and `req_ready` rises after NCC + 136 cycles.
- R9: For kind 1, `rsp_crc_err` is set when reply bits 7..1 differ from the CRC7 of the first 40 reply bits.
- R10: For kind 2, no CRC is checked and `rsp_crc_err` is 0.
- R11: For kind 3, `rsp_crc_err` is set when reply bits 7..1 differ from the CRC7 of reply bits 127..8. The 8 header bits are left out of the check.
- R12: `rsp_frame_err` is set when the reply's end bit is 0 or its direction bit (second bit) is 1. On a timeout, both error flags are 0.
- R13: `card_clk_en` is low in IDLE and high in every other cycle, including every cycle that `cmd_oe` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; one line bit per cycle |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Command request present |
| req_ready | output | 1 | High in IDLE; a request is taken when both are high |
| req_index | input | 6 | Command index |
| req_arg | input | 32 | Command argument |
| req_rtype | input | 2 | Reply kind: 0 none, 1 short with CRC, 2 short without CRC, 3 long |
| rsp_valid | output | 1 | One-cycle pulse when a reply or a timeout is reported |
| rsp_frame | output | 136 | Received reply, last bit at position 0 |
| rsp_timeout | output | 1 | No start bit within NCR_MAX cycles |
| rsp_crc_err | output | 1 | CRC mismatch in the reply |
| rsp_frame_err | output | 1 | Bad end bit or bad direction bit |
| card_clk_en | output | 1 | Card clock enable, high whenever the line is busy or timing a gap |
| cmd_out | output | 1 | Line value driven by the host |
| cmd_oe | output | 1 | Drive enable for the line |
| cmd_in | input | 1 | Sensed line value (pulled high when floating) |

## Verification
Commands are issued with each reply kind. Clean short replies and clean long replies check the two CRC ranges. Replies with a flipped CRC bit show that a check is active, and the same flip on kind 2 shows that the check is skipped there. Replies start at the earliest cycle, at middle delays and in the very last cycle of the window, which shows where the window ends. Silent cards are tried for both a short kind and the long kind, so that the extra 136-cycle gap is told apart from the plain one. A reply with a zero end bit isolates the framing check. The bench compares the drive, the line value, ready, clock enable and the pulse against its model on every clock, so an off-by-one in any gap shows up as a miscompare.

// File: rtl/cmdline_pkg.sv
package cmdline_pkg;

    typedef enum logic [1:0] {
        RT_NONE        = 2'd0,
        RT_SHORT       = 2'd1,
        RT_SHORT_NOCRC = 2'd2,
        RT_LONG        = 2'd3
    } rsp_kind_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT,
        ST_RECV,
        ST_GAP
    } seq_state_t;

    localparam int FRAME_SHORT = 48;
    localparam int FRAME_LONG  = 136;
    localparam int CMD_BODY    = 40;

    // One serial step of CRC7, generator x^7 + x^3 + 1
    function automatic logic [6:0] crc7_next(logic [6:0] c, logic b);
        logic fb;
        fb = b ^ c[6];
        return {c[5:3], c[2] ^ fb, c[1:0], fb};
    endfunction

endpackage

// File: rtl/cmdline_crc7.sv
module cmdline_crc7
    import cmdline_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    input  logic       din,
    output logic [6:0] crc
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            crc <= '0;
        else if (clr)
            crc <= '0;
        else if (en)
            crc <= crc7_next(crc, din);
    end

endmodule

// File: rtl/cmdline_rx.sv
module cmdline_rx
    import cmdline_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  shift_en,
    input  logic                  din,
    input  logic                  long_frame,
    output logic                  last,
    output logic [FRAME_LONG-1:0] frame,
    output logic                  crc_ok,
    output logic                  dir_ok,
    output logic                  end_ok
);

    localparam int PW = $clog2(FRAME_LONG + 1);

    logic [FRAME_LONG-2:0] sh;
    logic [PW-1:0]         pos;
    logic [PW-1:0]         len_m1;
    logic                  crc_take;
    logic [6:0]            crc;

    assign len_m1   = long_frame ? PW'(FRAME_LONG - 1) : PW'(FRAME_SHORT - 1);
    assign last     = shift_en && (pos == len_m1);
    assign frame    = {sh, din};
    // long replies: header (8 bits) and trailer left out of the check
    assign crc_take = shift_en && (long_frame ? (pos >= PW'(8) && pos < PW'(FRAME_LONG - 8))
                                              : (pos < PW'(CMD_BODY)));
    assign crc_ok   = (crc == frame[7:1]);
    assign dir_ok   = long_frame ? !sh[FRAME_LONG-3] : !sh[FRAME_SHORT-3];
    assign end_ok   = din;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh  <= '0;
            pos <= '0;
        end else if (start) begin
            sh  <= '0;           // start bit (0) is the first bit held
            pos <= PW'(1);
        end else if (shift_en) begin
            sh  <= {sh[FRAME_LONG-3:0], din};
            pos <= pos + PW'(1);
        end
    end

    cmdline_crc7 u_crc (
        .clk (clk),
        .rst_n(rst_n),
        .clr (start),
        .en  (crc_take),
        .din (din),
        .crc (crc)
    );

endmodule

// File: rtl/cmdline_seq.sv
module cmdline_seq
    import cmdline_pkg::*;
#(
    parameter int NRC      = 8,
    parameter int NCC      = 8,
    parameter int NCR_MAX  = 64,
    parameter int ID_EXTRA = 136
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [5:0]            req_index,
    input  logic [31:0]           req_arg,
    input  logic [1:0]            req_rtype,
    output logic                  rsp_valid,
    output logic [FRAME_LONG-1:0] rsp_frame,
    output logic                  rsp_timeout,
    output logic                  rsp_crc_err,
    output logic                  rsp_frame_err,
    output logic                  card_clk_en,
    output logic                  cmd_out,
    output logic                  cmd_oe,
    input  logic                  cmd_in
);

    localparam int CMAX = NCC + ID_EXTRA + NRC + NCR_MAX + FRAME_SHORT;
    localparam int CW   = $clog2(CMAX + 1);

    seq_state_t            state;
    rsp_kind_t             kind;
    logic [CW-1:0]         cnt;
    logic [CW-1:0]         gap_len;
    logic [CMD_BODY-1:0]   tx_sh;
    logic [6:0]            tx_crc;
    logic [2:0]            crc_sel;
    logic                  accept;
    logic                  tx_body;
    logic                  no_answer;
    logic                  start_seen;
    logic                  rx_last;
    logic [FRAME_LONG-1:0] rx_frame;
    logic                  rx_crc_ok, rx_dir_ok, rx_end_ok;

    assign accept     = (state == ST_IDLE) && req_valid;
    assign tx_body    = (state == ST_SEND) && (cnt < CW'(CMD_BODY));
    assign start_seen = (state == ST_WAIT) && !cmd_in;
    assign no_answer  = (state == ST_WAIT) && cmd_in && (cnt == CW'(NCR_MAX - 1));
    assign crc_sel    = 3'(CW'(FRAME_SHORT - 2) - cnt);

    // state register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            kind    <= RT_NONE;
            cnt     <= '0;
            gap_len <= CW'(1);
            tx_sh   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (accept) begin
                    tx_sh <= {2'b01, req_index, req_arg};
                    kind  <= rsp_kind_t'(req_rtype);
                    cnt   <= '0;
                    state <= ST_SEND;
                end
                ST_SEND: begin
                    if (tx_body) tx_sh <= {tx_sh[CMD_BODY-2:0], 1'b0};
                    if (cnt == CW'(FRAME_SHORT - 1)) begin
                        cnt <= '0;
                        if (kind == RT_NONE) begin
                            gap_len <= CW'(NCC);
                            state   <= ST_GAP;
                        end else begin
                            state   <= ST_WAIT;
                        end
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                ST_WAIT: begin
                    if (start_seen) begin
                        state <= ST_RECV;
                    end else if (no_answer) begin
                        gap_len <= (kind == RT_LONG) ? CW'(NCC + ID_EXTRA) : CW'(NCC);
                        cnt     <= '0;
                        state   <= ST_GAP;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                ST_RECV: if (rx_last) begin
                    gap_len <= CW'(NRC);
                    cnt     <= '0;
                    state   <= ST_GAP;
                end
                ST_GAP: begin
                    if (cnt == gap_len - CW'(1)) state <= ST_IDLE;
                    else                         cnt   <= cnt + CW'(1);
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // line and handshake outputs
    always_comb begin
        req_ready   = (state == ST_IDLE);
        card_clk_en = (state != ST_IDLE);
        cmd_oe      = (state == ST_SEND);
        cmd_out     = 1'b1;
        if (state == ST_SEND) begin
            if (cnt < CW'(CMD_BODY))             cmd_out = tx_sh[CMD_BODY-1];
            else if (cnt < CW'(FRAME_SHORT - 1)) cmd_out = tx_crc[crc_sel];
            else                                 cmd_out = 1'b1;
        end
    end

    // reply report
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid     <= 1'b0;
            rsp_frame     <= '0;
            rsp_timeout   <= 1'b0;
            rsp_crc_err   <= 1'b0;
            rsp_frame_err <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            if (no_answer) begin
                rsp_valid     <= 1'b1;
                rsp_frame     <= '0;
                rsp_timeout   <= 1'b1;
                rsp_crc_err   <= 1'b0;
                rsp_frame_err <= 1'b0;
            end else if (rx_last) begin
                rsp_valid     <= 1'b1;
                rsp_frame     <= rx_frame;
                rsp_timeout   <= 1'b0;
                rsp_crc_err   <= (kind != RT_SHORT_NOCRC) && !rx_crc_ok;
                rsp_frame_err <= !rx_end_ok || !rx_dir_ok;
            end
        end
    end

    cmdline_crc7 u_txcrc (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (accept),
        .en   (tx_body),
        .din  (tx_sh[CMD_BODY-1]),
        .crc  (tx_crc)
    );

    cmdline_rx u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_seen),
        .shift_en  (state == ST_RECV),
        .din       (cmd_in),
        .long_frame(kind == RT_LONG),
        .last      (rx_last),
        .frame     (rx_frame),
        .crc_ok    (rx_crc_ok),
        .dir_ok    (rx_dir_ok),
        .end_ok    (rx_end_ok)
    );

endmodule

// File: rtl/cmdline_seq_chk.sv
module cmdline_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic cmd_oe,
    input logic cmd_out,
    input logic card_clk_en,
    input logic rsp_valid,
    input logic rsp_timeout,
    input logic rsp_crc_err,
    input logic rsp_frame_err
);

    // R3
    drive_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_oe |-> !req_ready);

    // R1
    accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (cmd_oe && !cmd_out));

    // R1
    end_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_oe) |-> $past(cmd_out));

    // R6
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R12
    timeout_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_timeout) |-> (!rsp_crc_err && !rsp_frame_err));

    // R13
    clk_on_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_oe |-> card_clk_en);

endmodule

bind cmdline_seq cmdline_seq_chk u_chk (.*);

// File: tb/sim_cmdline_seq.sv
module sim_cmdline_seq;

    localparam int CLK_PERIOD = 10;
    localparam int NRC = 8, NCC = 8, NCR_MAX = 64, ID_EXTRA = 136;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [5:0]   req_index = '0;
    logic [31:0]  req_arg = '0;
    logic [1:0]   req_rtype = '0;
    logic         rsp_valid;
    logic [135:0] rsp_frame;
    logic         rsp_timeout, rsp_crc_err, rsp_frame_err;
    logic         card_clk_en, cmd_out, cmd_oe;
    logic         cmd_in = 1'b1;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmdline_seq #(.NRC(NRC), .NCC(NCC), .NCR_MAX(NCR_MAX), .ID_EXTRA(ID_EXTRA)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_index(req_index), .req_arg(req_arg), .req_rtype(req_rtype),
        .rsp_valid(rsp_valid), .rsp_frame(rsp_frame), .rsp_timeout(rsp_timeout),
        .rsp_crc_err(rsp_crc_err), .rsp_frame_err(rsp_frame_err),
        .card_clk_en(card_clk_en), .cmd_out(cmd_out), .cmd_oe(cmd_oe), .cmd_in(cmd_in));

    task automatic chk(string tag, string what, logic [135:0] act, logic [135:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // CRC7 by polynomial division over bits v[hi] down to v[lo]
    function automatic logic [6:0] ref_crc(logic [135:0] v, int hi, int lo);
        logic [6:0] c = '0;
        for (int i = hi; i >= lo; i--) begin
            logic top = c[6] ^ v[i];
            c = {c[5:0], 1'b0};
            if (top) c = c ^ 7'h09;
        end
        return c;
    endfunction

    // dly = 0: the card never answers
    task automatic txn(input logic [5:0] idx, input logic [31:0] arg, input int rt,
                       input int dly, input bit flip, input bit bad_end);
        logic [135:0] c, r;
        int L, V, E;
        string gtag;
        c = '0;
        c[47:8] = {2'b01, idx, arg};
        c[7:1]  = ref_crc(c, 47, 8);
        c[0]    = 1'b1;
        r = '0;
        L = (rt == 3) ? 136 : 48;
        if (rt == 3) begin
            r[135:128] = 8'h3F;
            r[127:8]   = {arg, ~arg, arg ^ 32'h5A5A_0F0F, arg[23:0]};
            r[7:1]     = ref_crc(r, 127, 8);
        end else begin
            r[47:8] = {2'b00, idx, ~arg};
            r[7:1]  = (rt == 2) ? 7'h7F : ref_crc(r, 47, 8);
        end
        if (flip) r[3] = ~r[3];
        r[0] = !bad_end;

        if (rt == 0) begin
            V = -1; E = 49 + NCC; gtag = "R5";
        end else if (dly == 0) begin
            V = 49 + NCR_MAX;
            E = V + NCC + ((rt == 3) ? ID_EXTRA : 0);
            gtag = (rt == 3) ? "R8" : "R7";
        end else begin
            V = 48 + dly + L; E = V + NRC; gtag = "R4";
        end

        chk(gtag, "ready at entry", req_ready, 1);
        req_index = idx; req_arg = arg; req_rtype = 2'(rt); req_valid = 1'b1;
        for (int k = 1; k <= E; k++) begin
            @(negedge clk);
            if (k == 1) req_valid = 1'b0;
            if (k <= 48) begin
                chk("R3", "oe in frame", cmd_oe, 1);
                chk((k > 40 && k < 48) ? "R2" : "R1", "cmd bit", cmd_out, c[48-k]);
                chk("R3", "ready in frame", req_ready, 0);
            end else begin
                chk("R3", "oe released", cmd_oe, 0);
                chk(gtag, "ready gap", req_ready, (k == E));
            end
            chk("R13", "clk_en", card_clk_en, (k != E));
            chk("R6", "rsp_valid", rsp_valid, (k == V));
            if (k == V) begin
                chk(gtag == "R4" ? "R6" : gtag, "timeout flag", rsp_timeout, (dly == 0));
                if (dly != 0) chk("R6", "frame", rsp_frame, r);
                chk(rt == 3 ? "R11" : (rt == 2 ? "R10" : "R9"), "crc_err",
                    rsp_crc_err, (dly != 0) && flip && (rt != 2));
                chk("R12", "frame_err", rsp_frame_err, (dly != 0) && bad_end);
            end
            if (rt != 0 && dly != 0 && k >= 48 + dly && k < 48 + dly + L)
                cmd_in = r[L - 1 - (k - 48 - dly)];
            else
                cmd_in = 1'b1;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R3", "reset oe", cmd_oe, 0);
        chk("R13", "reset clk_en", card_clk_en, 0);
        chk("R6", "reset rsp_valid", rsp_valid, 0);
        chk("R5", "reset ready", req_ready, 1);

        txn(6'd0,  32'h0000_0000, 0, 0, 0, 0);           // R1 R5 all-zero body
        txn(6'd55, 32'hFFFF_FFFF, 0, 0, 0, 0);           // R1 R2 all-ones argument
        txn(6'd8,  32'h0000_01AA, 1, 3, 0, 0);           // R6 R9 clean short
        txn(6'd17, 32'h1234_5678, 1, 1, 0, 0);           // R6 earliest start
        txn(6'd18, 32'hCAFE_0001, 1, NCR_MAX, 0, 0);     // R6 last cycle of window
        txn(6'd13, 32'h8000_0001, 1, 5, 1, 0);           // R9 flipped crc
        txn(6'd41, 32'h00FF_8000, 2, 4, 1, 0);           // R10 no crc check
        txn(6'd2,  32'hA5A5_3C3C, 3, 2, 0, 0);           // R11 clean long
        txn(6'd9,  32'h0F0F_F0F0, 3, 6, 1, 0);           // R11 flipped crc
        txn(6'd7,  32'h2222_1111, 1, 4, 0, 1);           // R12 end bit 0
        txn(6'd55, 32'h0000_0000, 1, 0, 0, 0);           // R7 silent short
        txn(6'd2,  32'h0000_0000, 3, 0, 0, 0);           // R8 silent long
        txn(6'd3,  32'h7654_3210, 0, 0, 0, 0);           // R5 after the long gap

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule